// File: doc/BRIEF.md
# Serial Receiver with Flagged Receive Queue

This block receives asynchronous serial characters on a single line and stores them in a four-entry receive queue. The line is sampled on a 16x oversample tick supplied from outside. A falling edge opens a candidate start bit, which is confirmed at its midpoint. The receiver then shifts in eight data bits, least significant first. A ninth bit follows when either parity or extra-bit mode is on. The frame closes when the stop bit is sampled at its midpoint.

Each queue entry holds the byte, an extra-bit field and a parity-error mark. The head entry sits on the read outputs and leaves the queue on a pop strobe. Three flags are held in status registers: overrun, parity error and receive event. Each flag stays set until its own clear strobe. The parity-error flag and the extra-bit output always describe the head entry, not the character most recently received. Dropping the receive enable halts reception, but the queue can still be read out.

Top module: `uart_rx_flagq`

## Requirements
- R1: Characters are read from `rd_data` in arrival order. Each character is a low start bit followed by data bits, least significant bit first, with every bit sampled at its midpoint on the 16x tick. `pop` removes the head entry; a `pop` while the queue is empty has no effect.
- R2: A low level seen on the line counts as a start bit only if the line is still low at the start bit's midpoint (8 ticks later). Otherwise the receiver returns to idle and stores nothing.
- R3: The queue holds at most 4 entries. `fifo_count` gives the number held, and `rd_valid` is high exactly when that number is non-zero.
- R4: A character that completes while the queue holds 4 entries, with no pop in the same cycle, is discarded and sets `ovr_flag`. `ovr_flag` stays set until `clr_ovr` is pulsed.
- R5: `ri_flag` is set in the cycle after the stop bit is sampled and stays set until `clr_ri` is pulsed.
- R6: A ninth bit slot follows the data bits whenever `par_en` or `xbit_en` is high.
- R7: The extra-bit field of a stored entry depends on the mode. With `xbit_en` high and `par_en` low, it holds the ninth bit. Otherwise it holds the level of the stop bit. `xbit_flag` shows this field for the head entry.
- R8: With `par_en` high, an entry is marked as a parity error when the received ninth bit differs from the expected parity bit. `par_type` selects that bit: 0 = odd (bit set so the total count of ones is odd), 1 = even, 2 = always 1, 3 = always 0.
- R9: `perr_flag` is set while `par_en` is high and the head entry carries a parity-error mark, and it stays set until cleared. When `clr_perr` is pulsed while such an entry is still at the head, the set wins. The flag therefore follows the head, and it can first rise when an erroring entry reaches the head through a pop.
- R10: While `rx_en` is low, no character is received and any frame in progress is abandoned. Entries already in the queue can still be read and popped.
- R11: After reset the queue is empty and `ovr_flag`, `perr_flag` and `ri_flag` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial input line, idles high |
| rx_en | input | 1 | Receive enable |
| par_en | input | 1 | Parity mode on |
| par_type | input | 2 | Parity selection (0 odd, 1 even, 2 one, 3 zero) |
| xbit_en | input | 1 | Ninth-bit capture mode on |
| pop | input | 1 | Remove the head entry |
| clr_ovr | input | 1 | Clear strobe for the overrun flag |
| clr_perr | input | 1 | Clear strobe for the parity-error flag |
| clr_ri | input | 1 | Clear strobe for the receive flag |
| rd_data | output | 8 | Data byte of the head entry |
| rd_valid | output | 1 | Queue is not empty |
| xbit_flag | output | 1 | Extra-bit field of the head entry |
| fifo_count | output | 3 | Number of entries held |
| ovr_flag | output | 1 | Sticky overrun flag |
| perr_flag | output | 1 | Sticky parity-error flag for the head entry |
| ri_flag | output | 1 | Sticky receive-event flag |

## Verification
Some properties are checked on every cycle. The queue never exceeds its depth, and `rd_valid` agrees with the count. A completion into a full queue leaves the count unchanged and raises overrun. Every completed frame raises the receive flag. The three flags hold until their clear strobes. The parity-error flag rises whenever an erroring entry sits at the head. No frame completes after the enable has dropped.

Other behaviours can only be shown by the bench's scenarios. These are the bit order and midpoint sampling of whole frames, and rejection of a short low glitch. They also include the ninth-bit and stop-level capture in each mode and all four parity selections. Finally, the scenarios show that only the first four of five back-to-back characters survive an overrun.

// File: rtl/uart_rx_flagq_pkg.sv
package uart_rx_flagq_pkg;

  localparam int unsigned RX_DW = 8;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_NINTH,
    RX_STOP
  } rx_state_e;

  typedef struct packed {
    logic             perr;
    logic             xbit;
    logic [RX_DW-1:0] data;
  } rx_entry_t;

  // Parity bit the sender is expected to append for a given selection.
  function automatic logic want_parity(input logic [RX_DW-1:0] d, input logic [1:0] sel);
    logic r;
    case (sel)
      2'd0:    r = ~(^d);   // odd total
      2'd1:    r = ^d;      // even total
      2'd2:    r = 1'b1;
      default: r = 1'b0;
    endcase
    return r;
  endfunction

  // Value kept in the extra-bit slot of an entry.
  function automatic logic pick_xbit(input logic xmode, input logic pmode,
                                     input logic ninth, input logic stop);
    return (xmode && !pmode) ? ninth : stop;
  endfunction

endpackage

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
  import uart_rx_flagq_pkg::*;
#(
  parameter int unsigned OVS = 16,
  parameter int unsigned DW  = RX_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          os_tick,
  input  logic          rxd,
  input  logic          rx_en,
  input  logic          ninth_en,
  output logic          frame_done,
  output logic [DW-1:0] frame_data,
  output logic          frame_ninth,
  output logic          frame_stop
);

  localparam int unsigned CW   = $clog2(OVS);
  localparam int unsigned BW   = (DW > 1) ? $clog2(DW) : 1;
  localparam int unsigned HALF = OVS / 2;

  logic [1:0]    sync_q;
  logic          rx_s;
  rx_state_e     state;
  logic [CW-1:0] os_cnt;
  logic [BW-1:0] bit_idx;
  logic [DW-1:0] shreg;
  logic          ninth_q;
  logic          at_mid;
  logic          at_full;

  assign rx_s    = sync_q[1];
  assign at_mid  = (os_cnt == CW'(HALF - 1));
  assign at_full = (os_cnt == CW'(OVS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= RX_IDLE;
      os_cnt  <= '0;
      bit_idx <= '0;
      shreg   <= '0;
      ninth_q <= 1'b0;
    end else if (!rx_en) begin
      state  <= RX_IDLE;
      os_cnt <= '0;
    end else if (os_tick) begin
      case (state)
        RX_IDLE: begin
          if (!rx_s) begin
            state  <= RX_START;
            os_cnt <= '0;
          end
        end
        RX_START: begin
          if (at_mid) begin
            os_cnt  <= '0;
            bit_idx <= '0;
            state   <= rx_s ? RX_IDLE : RX_DATA;
          end else begin
            os_cnt <= os_cnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (at_full) begin
            os_cnt <= '0;
            shreg  <= {rx_s, shreg[DW-1:1]};
            if (bit_idx == BW'(DW - 1)) state <= ninth_en ? RX_NINTH : RX_STOP;
            else                        bit_idx <= bit_idx + 1'b1;
          end else begin
            os_cnt <= os_cnt + 1'b1;
          end
        end
        RX_NINTH: begin
          if (at_full) begin
            os_cnt  <= '0;
            ninth_q <= rx_s;
            state   <= RX_STOP;
          end else begin
            os_cnt <= os_cnt + 1'b1;
          end
        end
        RX_STOP: begin
          if (at_full) begin
            os_cnt <= '0;
            state  <= RX_IDLE;
          end else begin
            os_cnt <= os_cnt + 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  assign frame_done  = rx_en && os_tick && (state == RX_STOP) && at_full;
  assign frame_data  = shreg;
  assign frame_ninth = ninth_q;
  assign frame_stop  = rx_s;

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 10
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           push,
  input  logic [W-1:0]                   wdata,
  input  logic                           pop,
  output logic [W-1:0]                   rdata,
  output logic [$clog2(DEPTH+1)-1:0]     count,
  output logic                           full,
  output logic                           empty,
  output logic                           dropped
);

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNTW = $clog2(DEPTH + 1);

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [W-1:0]  slot [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic          do_pop;
  logic          do_push;

  assign full    = (count == CNTW'(DEPTH));
  assign empty   = (count == '0);
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign dropped = push && !do_push;
  assign rdata   = slot[rd_ptr];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              slot[g] <= '0;
      else if (do_push && wr_ptr == AW'(g))    slot[g] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_done,
  input  logic dropped,
  input  logic head_perr_seen,
  input  logic clr_ovr,
  input  logic clr_perr,
  input  logic clr_ri,
  output logic ovr_flag,
  output logic perr_flag,
  output logic ri_flag
);

  function automatic logic sticky(input logic cur, input logic clr, input logic set);
    return (cur && !clr) || set;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_flag  <= 1'b0;
      perr_flag <= 1'b0;
      ri_flag   <= 1'b0;
    end else begin
      ovr_flag  <= sticky(ovr_flag,  clr_ovr,  dropped);
      perr_flag <= sticky(perr_flag, clr_perr, head_perr_seen);
      ri_flag   <= sticky(ri_flag,   clr_ri,   frame_done);
    end
  end

endmodule

// File: rtl/uart_rx_flagq.sv
module uart_rx_flagq
  import uart_rx_flagq_pkg::*;
#(
  parameter int unsigned OVS   = 16,
  parameter int unsigned DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       os_tick,
  input  logic                       rxd,
  input  logic                       rx_en,
  input  logic                       par_en,
  input  logic [1:0]                 par_type,
  input  logic                       xbit_en,
  input  logic                       pop,
  input  logic                       clr_ovr,
  input  logic                       clr_perr,
  input  logic                       clr_ri,
  output logic [RX_DW-1:0]           rd_data,
  output logic                       rd_valid,
  output logic                       xbit_flag,
  output logic [$clog2(DEPTH+1)-1:0] fifo_count,
  output logic                       ovr_flag,
  output logic                       perr_flag,
  output logic                       ri_flag
);

  localparam int unsigned EW = $bits(rx_entry_t);

  // Named internal events, also observed by the bound checker.
  logic             frame_done;
  logic [RX_DW-1:0] frame_data;
  logic             frame_ninth;
  logic             frame_stop;
  logic             fifo_full;
  logic             fifo_empty;
  logic             fifo_drop;
  logic             head_perr;
  rx_entry_t        new_entry;
  rx_entry_t        head_entry;
  logic [EW-1:0]    head_raw;

  uart_rx_framer #(.OVS(OVS), .DW(RX_DW)) u_framer (
    .clk         (clk),
    .rst_n       (rst_n),
    .os_tick     (os_tick),
    .rxd         (rxd),
    .rx_en       (rx_en),
    .ninth_en    (par_en | xbit_en),
    .frame_done  (frame_done),
    .frame_data  (frame_data),
    .frame_ninth (frame_ninth),
    .frame_stop  (frame_stop)
  );

  always_comb begin
    new_entry.data = frame_data;
    new_entry.xbit = pick_xbit(xbit_en, par_en, frame_ninth, frame_stop);
    new_entry.perr = par_en && (frame_ninth != want_parity(frame_data, par_type));
  end

  uart_rx_fifo #(.DEPTH(DEPTH), .W(EW)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (frame_done),
    .wdata   (new_entry),
    .pop     (pop),
    .rdata   (head_raw),
    .count   (fifo_count),
    .full    (fifo_full),
    .empty   (fifo_empty),
    .dropped (fifo_drop)
  );

  assign head_entry = rx_entry_t'(head_raw);
  assign rd_valid   = !fifo_empty;
  assign rd_data    = head_entry.data;
  assign xbit_flag  = head_entry.xbit;
  assign head_perr  = rd_valid && head_entry.perr;

  uart_rx_flags u_flags (
    .clk            (clk),
    .rst_n          (rst_n),
    .frame_done     (frame_done),
    .dropped        (fifo_drop),
    .head_perr_seen (head_perr && par_en),
    .clr_ovr        (clr_ovr),
    .clr_perr       (clr_perr),
    .clr_ri         (clr_ri),
    .ovr_flag       (ovr_flag),
    .perr_flag      (perr_flag),
    .ri_flag        (ri_flag)
  );

endmodule

// File: rtl/uart_rx_flagq_chk.sv
module uart_rx_flagq_chk #(
  parameter int unsigned DEPTH = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       rx_en,
  input logic                       par_en,
  input logic                       pop,
  input logic                       clr_ovr,
  input logic                       clr_perr,
  input logic                       clr_ri,
  input logic [$clog2(DEPTH+1)-1:0] fifo_count,
  input logic                       rd_valid,
  input logic                       ovr_flag,
  input logic                       perr_flag,
  input logic                       ri_flag,
  input logic                       frame_done,
  input logic                       fifo_full,
  input logic                       head_perr
);

  p_fifo_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= ($clog2(DEPTH+1))'(DEPTH));

  p_valid_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid == (fifo_count != '0));

  p_drop_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && fifo_full && !pop |=> ovr_flag && $stable(fifo_count));

  p_ovr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_flag && !clr_ovr |=> ovr_flag);

  p_ri_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> ri_flag);

  p_ri_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ri_flag && !clr_ri |=> ri_flag);

  p_perr_head_r9: assert property (@(posedge clk) disable iff (!rst_n)
    head_perr && par_en |=> perr_flag);

  p_perr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    perr_flag && !clr_perr |=> perr_flag);

  p_rxen_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !frame_done);

endmodule

bind uart_rx_flagq uart_rx_flagq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_en      (rx_en),
  .par_en     (par_en),
  .pop        (pop),
  .clr_ovr    (clr_ovr),
  .clr_perr   (clr_perr),
  .clr_ri     (clr_ri),
  .fifo_count (fifo_count),
  .rd_valid   (rd_valid),
  .ovr_flag   (ovr_flag),
  .perr_flag  (perr_flag),
  .ri_flag    (ri_flag),
  .frame_done (frame_done),
  .fifo_full  (fifo_full),
  .head_perr  (head_perr)
);

// File: tb/uart_rx_flagq_bench.sv
`timescale 1ns/1ps
module uart_rx_flagq_bench;

  localparam int TDIV    = 4;
  localparam int BIT_CYC = 16 * TDIV;
  localparam int DEPTH   = 4;

  typedef struct packed {
    logic       chk_x;
    logic       perr;
    logic       xbit;
    logic [7:0] data;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxd = 1'b1;
  logic rx_en = 1'b0;
  logic par_en = 1'b0;
  logic [1:0] par_type = 2'd0;
  logic xbit_en = 1'b0;
  logic pop = 1'b0;
  logic clr_ovr = 1'b0;
  logic clr_perr = 1'b0;
  logic clr_ri = 1'b0;
  logic [7:0] rd_data;
  logic rd_valid, xbit_flag, ovr_flag, perr_flag, ri_flag;
  logic [2:0] fifo_count;
  logic [1:0] tdiv = 2'd0;
  logic os_tick;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  exp_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) tdiv <= tdiv + 2'd1;
  assign os_tick = (tdiv == 2'd3);

  uart_rx_flagq u_uart_rx_flagq (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd), .rx_en(rx_en),
    .par_en(par_en), .par_type(par_type), .xbit_en(xbit_en), .pop(pop),
    .clr_ovr(clr_ovr), .clr_perr(clr_perr), .clr_ri(clr_ri),
    .rd_data(rd_data), .rd_valid(rd_valid), .xbit_flag(xbit_flag),
    .fifo_count(fifo_count), .ovr_flag(ovr_flag), .perr_flag(perr_flag),
    .ri_flag(ri_flag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic par_bit(input logic [7:0] d, input logic [1:0] t);
    int ones = $countones(d);
    case (t)
      2'd0: return (ones % 2 == 0);
      2'd1: return (ones % 2 == 1);
      2'd2: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  // Driver: serialises one frame and records the expected queue entry.
  task automatic send(input logic [7:0] d, input logic has9, input logic b9);
    exp_t e;
    rxd = 1'b0; wait_cyc(BIT_CYC);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; wait_cyc(BIT_CYC); end
    if (has9) begin rxd = b9; wait_cyc(BIT_CYC); end
    rxd = 1'b1; wait_cyc(2 * BIT_CYC);
    e.data  = d;
    e.chk_x = !par_en;
    e.xbit  = (xbit_en && !par_en) ? b9 : 1'b1;
    e.perr  = par_en && (b9 != par_bit(d, par_type));
    if (rx_en && sb.size() < DEPTH) sb.push_back(e);
  endtask

  // Monitor: reads the head, compares with the scoreboard, pops.
  task automatic drain(input string tag);
    exp_t e;
    while (sb.size() > 0) begin
      e = sb.pop_front();
      chk({tag, " R3 valid"}, rd_valid, 1'b1);
      chk({tag, " R1 data"}, rd_data, e.data);
      if (e.chk_x) chk({tag, " R7 xbit"}, xbit_flag, e.xbit);
      if (par_en) begin
        strobe(clr_perr);
        wait_cyc(2);
        chk({tag, " R9 perr follows head"}, perr_flag, e.perr);
      end
      strobe(pop);
      wait_cyc(2);
    end
    chk({tag, " R3 empty"}, fifo_count, 3'd0);
    strobe(clr_perr);
  endtask

  initial begin
    wait_cyc(5);
    chk("R11 count", fifo_count, 3'd0);
    chk("R11 valid", rd_valid, 1'b0);
    chk("R11 ovr", ovr_flag, 1'b0);
    chk("R11 perr", perr_flag, 1'b0);
    chk("R11 ri", ri_flag, 1'b0);
    rst_n = 1'b1;
    wait_cyc(5);
    chk("R11 count after release", fifo_count, 3'd0);
    rx_en = 1'b1;

    // Plain frames, stop level lands in the extra-bit field
    send(8'hA5, 1'b0, 1'b0);
    send(8'h3C, 1'b0, 1'b0);
    send(8'hFF, 1'b0, 1'b0);
    chk("R3 count three", fifo_count, 3'd3);
    chk("R5 ri set", ri_flag, 1'b1);
    wait_cyc(20);
    chk("R5 ri held", ri_flag, 1'b1);
    strobe(clr_ri); wait_cyc(1);
    chk("R5 ri cleared", ri_flag, 1'b0);
    drain("plain R1 R7");
    strobe(pop); wait_cyc(2);
    chk("R1 pop on empty", fifo_count, 3'd0);

    // Ninth bit as extra data
    xbit_en = 1'b1;
    send(8'h12, 1'b1, 1'b0);
    send(8'h34, 1'b1, 1'b1);
    send(8'h80, 1'b1, 1'b0);
    chk("R6 ninth count", fifo_count, 3'd3);
    drain("xbit R6 R7");
    xbit_en = 1'b0;

    // Parity, every selection, good then bad
    par_en = 1'b1;
    for (int t = 0; t < 4; t++) begin
      par_type = 2'(t);
      send(8'h96, 1'b1, par_bit(8'h96, 2'(t)));
      send(8'h07, 1'b1, ~par_bit(8'h07, 2'(t)));
      send(8'h07, 1'b1, par_bit(8'h07, 2'(t)));
      chk("R8 parity count", fifo_count, 3'd3);
      chk("R9 good head no perr", perr_flag, 1'b0);
      drain("parity R8");
    end
    par_en = 1'b0;
    par_type = 2'd0;

    // Overrun
    strobe(clr_ri);
    for (int k = 0; k < 5; k++) send(8'h40 + 8'(k), 1'b0, 1'b0);
    chk("R4 count capped", fifo_count, 3'd4);
    chk("R4 ovr set", ovr_flag, 1'b1);
    wait_cyc(50);
    chk("R4 ovr held", ovr_flag, 1'b1);
    strobe(clr_ovr); wait_cyc(1);
    chk("R4 ovr cleared", ovr_flag, 1'b0);
    drain("overrun R4");

    // Receive disabled
    strobe(clr_ri);
    rx_en = 1'b0;
    send(8'h55, 1'b0, 1'b0);
    chk("R10 no rx count", fifo_count, 3'd0);
    chk("R10 no rx ri", ri_flag, 1'b0);
    rx_en = 1'b1;
    send(8'h66, 1'b0, 1'b0);
    rx_en = 1'b0;
    wait_cyc(5);
    chk("R10 held count", fifo_count, 3'd1);
    drain("disabled read R10");
    rx_en = 1'b1;

    // Short glitch is not a start bit
    strobe(clr_ri);
    rxd = 1'b0; wait_cyc(3 * TDIV);
    rxd = 1'b1; wait_cyc(3 * BIT_CYC);
    chk("R2 glitch count", fifo_count, 3'd0);
    chk("R2 glitch ri", ri_flag, 1'b0);
    send(8'hC3, 1'b0, 1'b0);
    chk("R2 frame after glitch", fifo_count, 3'd1);
    drain("after glitch R2");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule